// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It takes one request at a time, either a byte program or a sector erase, over a valid/ready channel. It expands the request into the fixed command-write script that the flash expects, and drives every write with the chip-select, write-strobe and read-strobe lines timed in whole clock cycles. It then polls the target location until bit 7 of the returned byte shows completion, and returns a status on a second valid/ready channel.

A program request carries the byte the host believes is currently stored at the target. A program can only clear bits. If the request would need any bit to go from 0 to 1, the block refuses it at once and never touches the bus. A cycle-count watchdog bounds the polling phase, so a flash that never finishes ends in a timeout status and does not hang the block.

Back-pressure rules: `req_ready` is high only while the block is idle, and a request transfers on a clock edge where both `req_valid` and `req_ready` are high. A response stays on `rsp_valid`/`rsp_status`, unchanged, until the edge where `rsp_ready` is high. No new request is taken before that edge.

Top module: `nor_prog_seq`

## Requirements
- R1: A program request (`req_erase`=0) issues exactly four bus writes, as address/data: 555h/AAh, 2AAh/55h, 555h/A0h, then `req_addr`/`req_data`. Unlock addresses have all bits above bit 11 zero.
- R2: An erase request (`req_erase`=1) issues exactly six bus writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then `req_addr`/30h.
- R3: During every write cycle, `fl_ce_n` and `fl_we_n` are low, `fl_oe_n` is high and `fl_dq_oe` is 1. Write and read strobes never overlap.
- R4: `fl_we_n` stays low for exactly WP_CYC cycles per write. `fl_addr` and `fl_dq_out` stay stable from the falling strobe through the first cycle after it rises. The strobe then stays high for WPH_CYC cycles before the next write.
- R5: A poll read holds `fl_ce_n` and `fl_oe_n` low and `fl_we_n` high with `fl_dq_oe`=0 for RD_CYC cycles. `fl_dq_in` is sampled in the last of those cycles. Reads repeat with WPH_CYC idle cycles between them.
- R6: A program is polled at `req_addr`. It completes with status 00 at the first read whose bit 7 equals `req_data[7]`.
- R7: An erase is polled at the sector address `req_addr`. It completes with status 00 at the first read whose bit 7 is 1.
- R8: Polling ends with status 01 (timeout) at the first non-matching read sampled once at least TIMEOUT_CYC cycles have passed since polling began. A matching read always wins over the timeout.
- R9: A program request with any bit set in `req_data & ~req_prev` returns status 10 (rejected) and issues no bus write or read.
- R10: `req_ready` is high only when idle, with the bus quiet. A pending response holds `rsp_valid` and `rsp_status` until taken, and no request is accepted meanwhile.
- R11: After reset, all three strobes are high, `fl_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_erase | input | 1 | 1 = sector erase, 0 = byte program |
| req_addr | input | AW | Target byte address or sector address |
| req_data | input | 8 | Byte to program |
| req_prev | input | 8 | Byte currently held at the target (program only) |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 2 | 00 done, 01 timeout, 10 rejected |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Enable for the data driver |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| fl_we_n | output | 1 | Write strobe, active low |

## Verification
The hardest case to reach is the edge of the watchdog: the read that matches on the very last permitted poll, next to the read one poll later that must report a timeout. The bench's flash model returns the complement of the expected bit 7 for a chosen number of reads. It runs the block with a short watchdog and sets that number to one below and exactly at the poll where the window closes, then counts the reads taken. Response back-pressure is reached by holding `rsp_ready` low while offering a second request.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;
  localparam logic [11:0] UNLK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;
  localparam logic [7:0]  UNLK_KEY_A  = 8'hAA;
  localparam logic [7:0]  UNLK_KEY_B  = 8'h55;
  localparam logic [7:0]  CMD_BYTE    = 8'hA0;
  localparam logic [7:0]  CMD_ERSETUP = 8'h80;
  localparam logic [7:0]  CMD_SECTOR  = 8'h30;

  localparam logic [1:0] ST_DONE    = 2'b00;
  localparam logic [1:0] ST_TIMEOUT = 2'b01;
  localparam logic [1:0] ST_REJECT  = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_WLO, S_WHI, S_RD, S_GAP, S_RSP
  } seq_state_e;
endpackage

// File: rtl/nor_phase_timer.sv
module nor_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nor_unlock_script.sv
module nor_unlock_script
  import nor_prog_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          erase,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          last
);
  localparam logic [AW-1:0] ADDR_A = AW'(UNLK_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLK_ADDR_B);

  always_comb begin
    wr_addr = ADDR_A;
    wr_data = UNLK_KEY_A;
    last    = 1'b0;
    if (!erase) begin
      unique case (step)
        3'd0: begin wr_addr = ADDR_A; wr_data = UNLK_KEY_A; end
        3'd1: begin wr_addr = ADDR_B; wr_data = UNLK_KEY_B; end
        3'd2: begin wr_addr = ADDR_A; wr_data = CMD_BYTE;   end
        default: begin wr_addr = tgt_addr; wr_data = tgt_data; last = 1'b1; end
      endcase
    end else begin
      unique case (step)
        3'd0, 3'd3: begin wr_addr = ADDR_A; wr_data = UNLK_KEY_A; end
        3'd1, 3'd4: begin wr_addr = ADDR_B; wr_data = UNLK_KEY_B; end
        3'd2:       begin wr_addr = ADDR_A; wr_data = CMD_ERSETUP; end
        default:    begin wr_addr = tgt_addr; wr_data = CMD_SECTOR; last = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import nor_prog_pkg::*;
#(
  parameter int AW          = 17,
  parameter int WP_CYC      = 5,
  parameter int WPH_CYC     = 7,
  parameter int RD_CYC      = 4,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_erase,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic [7:0]    req_prev,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_status,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int MAXPH = (WP_CYC > WPH_CYC) ? ((WP_CYC > RD_CYC) ? WP_CYC : RD_CYC)
                                            : ((WPH_CYC > RD_CYC) ? WPH_CYC : RD_CYC);
  localparam int TW  = $clog2(MAXPH + 1);
  localparam int WDW = $clog2(TIMEOUT_CYC + 1) + 1;
  localparam logic [TW-1:0]  LD_WP  = TW'(WP_CYC - 1);
  localparam logic [TW-1:0]  LD_WPH = TW'(WPH_CYC - 1);
  localparam logic [TW-1:0]  LD_RD  = TW'(RD_CYC - 1);
  localparam logic [WDW-1:0] WD_LIM = WDW'(TIMEOUT_CYC);

  seq_state_e    state_q;
  logic          erase_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    step_q;
  logic [1:0]    status_q;
  logic [WDW-1:0] wd_q;

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;
  logic [AW-1:0] scr_addr;
  logic [7:0]    scr_data;
  logic          scr_last;
  logic          exp_bit7;
  logic          bad_bits;
  logic          in_write;
  logic          in_poll;

  nor_phase_timer #(.TW(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  nor_unlock_script #(.AW(AW)) scr_i (
    .erase(erase_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .wr_addr(scr_addr), .wr_data(scr_data), .last(scr_last)
  );

  assign exp_bit7 = erase_q ? 1'b1 : data_q[7];
  assign bad_bits = !req_erase && ((req_data & ~req_prev) != 8'h00);
  assign in_write = (state_q == S_WLO) || (state_q == S_WHI);
  assign in_poll  = (state_q == S_RD)  || (state_q == S_GAP);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = LD_WP;
    unique case (state_q)
      S_IDLE: if (req_valid && !bad_bits) begin tmr_load = 1'b1; tmr_val = LD_WP; end
      S_WLO:  if (tmr_done) begin tmr_load = 1'b1; tmr_val = LD_WPH; end
      S_WHI:  if (tmr_done) begin tmr_load = 1'b1; tmr_val = scr_last ? LD_RD : LD_WP; end
      S_RD:   if (tmr_done) begin tmr_load = 1'b1; tmr_val = LD_WPH; end
      S_GAP:  if (tmr_done) begin tmr_load = 1'b1; tmr_val = LD_RD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      erase_q  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      step_q   <= '0;
      status_q <= ST_DONE;
      wd_q     <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          erase_q <= req_erase;
          addr_q  <= req_addr;
          data_q  <= req_data;
          step_q  <= '0;
          if (bad_bits) begin
            status_q <= ST_REJECT;
            state_q  <= S_RSP;
          end else begin
            state_q  <= S_WLO;
          end
        end
        S_WLO: if (tmr_done) state_q <= S_WHI;
        S_WHI: if (tmr_done) begin
          if (scr_last) begin
            wd_q    <= '0;
            state_q <= S_RD;
          end else begin
            step_q  <= step_q + 3'd1;
            state_q <= S_WLO;
          end
        end
        S_RD: begin
          if (wd_q != {WDW{1'b1}}) wd_q <= wd_q + 1'b1;
          if (tmr_done) begin
            if (fl_dq_in[7] == exp_bit7) begin
              status_q <= ST_DONE;
              state_q  <= S_RSP;
            end else if (wd_q >= WD_LIM) begin
              status_q <= ST_TIMEOUT;
              state_q  <= S_RSP;
            end else begin
              state_q  <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (wd_q != {WDW{1'b1}}) wd_q <= wd_q + 1'b1;
          if (tmr_done) state_q <= S_RD;
        end
        S_RSP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == S_IDLE);
  assign rsp_valid  = (state_q == S_RSP);
  assign rsp_status = status_q;

  assign fl_we_n   = (state_q != S_WLO);
  assign fl_oe_n   = (state_q != S_RD);
  assign fl_ce_n   = !((state_q == S_WLO) || (state_q == S_RD));
  assign fl_dq_oe  = in_write;
  assign fl_dq_out = in_write ? scr_data : 8'h00;
  assign fl_addr   = in_write ? scr_addr : (in_poll ? addr_q : '0);
endmodule

// File: rtl/nor_prog_seq_chk.sv
module nor_prog_seq_chk #(
  parameter int AW     = 17,
  parameter int WP_CYC = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_status,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n
);
  logic [15:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_run <= '0;
    else if (!fl_we_n) lo_run <= lo_run + 16'd1;
    else               lo_run <= '0;
  end

  a_r3_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

  a_r5_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_ce_n && fl_we_n && !fl_dq_oe));

  a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we_n && lo_run != 16'd0) |-> (lo_run == 16'(WP_CYC)));

  a_r4_stable_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  a_r4_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  a_r10_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !rsp_valid));
endmodule

bind nor_prog_seq nor_prog_seq_chk #(.AW(AW), .WP_CYC(WP_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_status(rsp_status), .fl_addr(fl_addr),
  .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n),
  .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/nor_prog_seq_tb_top.sv
module nor_prog_seq_tb_top;
  localparam int AW = 17;
  localparam int WP = 5;
  localparam int WPH = 7;
  localparam int RDC = 4;
  localparam int TMO = 400;

  typedef struct packed {
    logic          erase;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic [7:0]    prev;
    logic [7:0]    busy;
    logic [1:0]    st;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 17'h01234, 8'h5A, 8'hFF, 8'd3, 2'b00},
    '{1'b0, 17'h1FFFF, 8'hC3, 8'hE7, 8'd0, 2'b00},
    '{1'b1, 17'h06000, 8'h00, 8'h00, 8'd5, 2'b00},
    '{1'b1, 17'h10000, 8'h00, 8'h00, 8'd0, 2'b00},
    '{1'b0, 17'h00555, 8'h0F, 8'h0E, 8'd0, 2'b10},
    '{1'b0, 17'h08000, 8'h80, 8'h00, 8'd0, 2'b10}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_erase = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic [7:0]    req_prev = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [1:0]    rsp_status;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_out;
  logic          fl_dq_oe;
  logic [7:0]    fl_dq_in;
  logic          fl_ce_n, fl_oe_n, fl_we_n;

  always #2 clk = ~clk;

  nor_prog_seq #(.AW(AW), .WP_CYC(WP), .WPH_CYC(WPH), .RD_CYC(RDC), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data), .req_prev(req_prev),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  int checks = 0;
  int fails  = 0;

  // flash model / bus monitor state (owned by the monitor)
  logic          mon_clr = 1'b0;
  int            busy_init = 0;
  logic          fin7 = 1'b1;
  logic [AW-1:0] poll_exp = '0;
  int            busy_left = 0;
  int            wr_n = 0, rd_n = 0, width_bad = 0, gap_bad = 0, hold_bad = 0, rd_addr_bad = 0, rd_len_bad = 0;
  int            lo_len = 0, hi_len = 0, rd_len = 0;
  logic          prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] lo_a;
  logic [7:0]    lo_d;
  logic [AW-1:0] wa_log [8];
  logic [7:0]    wd_log [8];

  assign fl_dq_in = (busy_left > 0) ? {~fin7, 7'h2B} : {fin7, 7'h31};

  always @(negedge clk) begin
    if (mon_clr) begin
      busy_left = busy_init; wr_n = 0; rd_n = 0; width_bad = 0; gap_bad = 0;
      hold_bad = 0; rd_addr_bad = 0; rd_len_bad = 0; lo_len = 0; hi_len = 100; rd_len = 0;
    end else begin
      if (!fl_we_n) begin
        if (lo_len == 0 && hi_len < WPH) gap_bad++;
        lo_len++; lo_a = fl_addr; lo_d = fl_dq_out;
      end else begin
        if (!prev_we) begin
          if (wr_n < 8) begin wa_log[wr_n] = lo_a; wd_log[wr_n] = lo_d; end
          wr_n++;
          if (lo_len != WP) width_bad++;
          if (fl_addr !== lo_a || fl_dq_out !== lo_d) hold_bad++;
          lo_len = 0; hi_len = 0;
        end
        hi_len++;
      end
      if (!fl_oe_n) begin
        rd_len++;
        if (fl_addr !== poll_exp) rd_addr_bad++;
      end else if (!prev_oe) begin
        rd_n++;
        if (rd_len != RDC) rd_len_bad++;
        if (busy_left > 0) busy_left--;
        rd_len = 0;
      end
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW+7:0] exp_write(input logic er, input int i,
                                             input logic [AW-1:0] a, input logic [7:0] d);
    logic [AW-1:0] ea; logic [7:0] ed;
    if (!er) begin
      case (i)
        0: begin ea = 'h555; ed = 8'hAA; end
        1: begin ea = 'h2AA; ed = 8'h55; end
        2: begin ea = 'h555; ed = 8'hA0; end
        default: begin ea = a; ed = d; end
      endcase
    end else begin
      case (i)
        0, 3: begin ea = 'h555; ed = 8'hAA; end
        1, 4: begin ea = 'h2AA; ed = 8'h55; end
        2: begin ea = 'h555; ed = 8'h80; end
        default: begin ea = a; ed = 8'h30; end
      endcase
    end
    return {ea, ed};
  endfunction

  task automatic clear_mon(input int busy, input logic f7, input logic [AW-1:0] pa);
    busy_init = busy; fin7 = f7; poll_exp = pa;
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic issue(input logic er, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic [7:0] p);
    @(negedge clk);
    req_erase = er; req_addr = a; req_data = d; req_prev = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    int n = 0;
    while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic take_rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    logic [AW+7:0] ew;
    int nw;
    clear_mon(int'(v.busy), v.erase ? 1'b1 : v.data[7], v.addr);
    issue(v.erase, v.addr, v.data, v.prev);
    wait_rsp();
    check({tag, " status"}, rsp_status, v.st);
    take_rsp();
    if (v.st == 2'b10) begin
      check({tag, " R9 no writes"}, wr_n, 0);
      check({tag, " R9 no reads"}, rd_n, 0);
    end else begin
      nw = v.erase ? 6 : 4;
      check({tag, v.erase ? " R2 write count" : " R1 write count"}, wr_n, nw);
      for (int i = 0; i < nw; i++) begin
        ew = exp_write(v.erase, i, v.addr, v.data);
        check({tag, v.erase ? " R2 write" : " R1 write"}, {wa_log[i], wd_log[i]}, ew);
      end
      check({tag, " R4 strobe width/gap/hold"}, width_bad + gap_bad + hold_bad, 0);
      check({tag, " R5 read length"}, rd_len_bad, 0);
      check({tag, v.erase ? " R7 poll addr" : " R6 poll addr"}, rd_addr_bad, 0);
      check({tag, v.erase ? " R7 poll count" : " R6 poll count"}, rd_n, int'(v.busy) + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ce_n", fl_ce_n, 1); check("R11 we_n", fl_we_n, 1);
    check("R11 oe_n", fl_oe_n, 1); check("R11 dq_oe", fl_dq_oe, 0);
    check("R11 req_ready", req_ready, 1); check("R11 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], $sformatf("vec%0d", k));

    // R8 boundary: match on the last permitted poll (37 busy reads) wins
    run_vec('{1'b0, 17'h00100, 8'h7E, 8'hFF, 8'd37, 2'b00}, "R8 last-poll match");
    // R8 one poll later: timeout after 38 reads (sample at 11*37+3 >= 400)
    clear_mon(38, 1'b1, 17'h0A000);
    issue(1'b1, 17'h0A000, 8'h00, 8'h00);
    wait_rsp();
    check("R8 timeout status", rsp_status, 2'b01);
    take_rsp();
    check("R8 reads before timeout", rd_n, 38);
    check("R8 R2 writes before timeout", wr_n, 6);

    // R10 back-pressure: response held, no second request accepted
    clear_mon(1, 1'b0, 17'h00042);
    issue(1'b0, 17'h00042, 8'h11, 8'hFF);
    wait_rsp();
    req_erase = 1'b1; req_addr = 17'h04000; req_valid = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 rsp_valid held", rsp_valid, 1);
    check("R10 status held", rsp_status, 2'b00);
    check("R10 req_ready low", req_ready, 0);
    check("R10 no extra writes", wr_n, 4);
    req_valid = 1'b0;
    take_rsp();
    check("R10 ready after take", req_ready, 1);
    check("R10 rsp dropped", rsp_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule